// File: doc/BRIEF.md
# Request/Acknowledge Handshake Crossing Monitor

This block is a synthesizable checker that sits beside a four-phase request/acknowledge transfer between two asynchronous clock domains. It runs entirely on the sending side's clock. It watches the request level and the payload bus directly. It watches the acknowledge level only after passing it through a two-flop synchronizer of its own. From these it tracks whether a request is outstanding and detects five kinds of misuse: a second request, an acknowledge with nothing pending, a withdrawn request, an acknowledge that never comes, and payload movement while the request is held.

Each violation class owns one bit. On the edge where a violation is detected, the class's bit in the pulse vector is high for one cycle and the matching sticky flag is set. The flag stays set until a synchronous clear. Two saturating counters record how many request rising edges and acknowledge rising edges have been seen, for coverage. The clear input empties the flags and both counters. An active-low asynchronous reset empties all state.

Top module: `hs_handshake_monitor`

## Requirements
- R1: The acknowledge input is passed through two flops before use. Its rising edge is acted on at the third rising clock edge after the input goes high, so its effects appear on the outputs after that edge.
- R2: Multiple-request. If request rises while an earlier request is still outstanding, bit 0 is reported. A request stays outstanding from its rising edge until a synchronized acknowledge rising edge, even if the request was dropped in between.
- R3: Acknowledge-without-request. If a synchronized acknowledge rising edge arrives while no request is outstanding, bit 1 is reported. A late acknowledge after a timeout still counts as answering the request.
- R4: Request-drop. If request falls while it is outstanding and no acknowledge edge is seen in the same cycle, bit 2 is reported.
- R5: Acknowledge-timeout. If a request stays outstanding with no acknowledge edge, bit 3 is reported exactly once, on the TIMEOUT-th rising edge after the edge that accepted the request.
- R6: Data-stability. If the payload differs from its value in the previous cycle, and request was high in both cycles, bit 4 is reported.
- R7: err_pulse shows each detection for exactly one cycle. The same bit of err_flags is set in that cycle and stays set until clr.
- R8: req_count and ack_count count rising edges of request and of synchronized acknowledge, not levels. Each increases by at most one per cycle and holds at its all-ones value.
- R9: When clr is high at a rising edge, err_flags and both counters are zero after that edge. This takes priority over any event in the same cycle.
- R10: While rst_n is low, all flags, pulses, counters and tracking state are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sending-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of flags and counters |
| req | input | 1 | Request level, sending-domain signal |
| ack | input | 1 | Acknowledge level from the receiving domain (asynchronous) |
| data | input | DATA_W (8) | Payload bus carried by the handshake |
| err_pulse | output | 5 | One-cycle violation strobes, bit order as in R2 to R6 |
| err_flags | output | 5 | Sticky violation flags, same bit order |
| req_count | output | CNT_W (16) | Saturating count of request rising edges |
| ack_count | output | CNT_W (16) | Saturating count of acknowledge rising edges |

## Verification
The properties assume that req, data and clr are synchronous to clk. They also assume that ack changes at most once every few cycles, so that each level it takes reaches the second synchronizer stage. The stimulus drives every input a quarter period after the rising edge and holds each acknowledge level for at least one full cycle. It also lets the synchronizer settle before each check on the acknowledge counter, so the fixed three-edge latency of R1 is what gets observed. Illegal sequences are produced on purpose, and each is timed so that only the violation being exercised can fire in that cycle.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int ERR_N     = 5;
  localparam int ERR_MULTI = 0;
  localparam int ERR_NOREQ = 1;
  localparam int ERR_DROP  = 2;
  localparam int ERR_TMO   = 3;
  localparam int ERR_DATA  = 4;

  typedef logic [ERR_N-1:0] err_vec_t;

  // Next outstanding state: a new request opens, an acknowledge edge closes.
  function automatic logic next_pending(logic cur, logic rise_req, logic rise_ack);
    return rise_req | (cur & ~rise_ack);
  endfunction
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  output logic ack_rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], ack_in};
  end

  assign ack_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hs_tracker.sv
module hs_tracker
  import hs_mon_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TIMEOUT = 64,
  localparam int WAIT_W = $clog2(TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DATA_W-1:0] data,
  input  logic              ack_rise,
  output logic              req_rise,
  output logic              pending,
  output logic [WAIT_W-1:0] wait_cnt,
  output err_vec_t          events
);
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              req_fall;
  logic              pending_n;
  logic              at_limit;

  assign req_rise  = req & ~req_q;
  assign req_fall  = ~req & req_q;
  assign pending_n = next_pending(pending, req_rise, ack_rise);
  assign at_limit  = (wait_cnt == WAIT_W'(TIMEOUT - 1));

  always_comb begin
    events            = '0;
    events[ERR_MULTI] = req_rise & pending;
    events[ERR_NOREQ] = ack_rise & ~pending;
    events[ERR_DROP]  = req_fall & pending & ~ack_rise;
    events[ERR_TMO]   = pending & ~ack_rise & at_limit;
    events[ERR_DATA]  = req & req_q & (data != data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      data_q   <= '0;
      pending  <= 1'b0;
      wait_cnt <= '0;
    end else begin
      req_q   <= req;
      data_q  <= data;
      pending <= pending_n;
      if (req_rise || !pending_n)
        wait_cnt <= '0;
      else if (wait_cnt != WAIT_W'(TIMEOUT))
        wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hs_sat_counter.sv
module hs_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (clr)                    count <= '0;
    else if (inc && count != '1)     count <= count + 1'b1;
  end
endmodule

// File: rtl/hs_handshake_monitor.sv
module hs_handshake_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 64,
  parameter int SYNC_N  = 2,
  localparam int WAIT_W = $clog2(TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req,
  input  logic              ack,
  input  logic [DATA_W-1:0] data,
  output logic [ERR_N-1:0]  err_pulse,
  output logic [ERR_N-1:0]  err_flags,
  output logic [CNT_W-1:0]  req_count,
  output logic [CNT_W-1:0]  ack_count
);
  logic              ack_rise;
  logic              req_rise;
  logic              pending;
  logic [WAIT_W-1:0] wait_cnt;
  err_vec_t          events;
  logic [1:0]        cov_inc;
  logic [CNT_W-1:0]  cov_val [2];

  hs_ack_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .ack_in(ack), .ack_rise(ack_rise)
  );

  hs_tracker #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) trk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .data(data), .ack_rise(ack_rise),
    .req_rise(req_rise), .pending(pending), .wait_cnt(wait_cnt), .events(events)
  );

  assign cov_inc = {ack_rise, req_rise};

  for (genvar g = 0; g < 2; g++) begin : g_cov
    hs_sat_counter #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cov_inc[g]), .count(cov_val[g])
    );
  end

  assign req_count = cov_val[0];
  assign ack_count = cov_val[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= '0;
      err_flags <= '0;
    end else begin
      err_pulse <= events;
      err_flags <= clr ? '0 : (err_flags | events);
    end
  end
endmodule

// File: rtl/hs_mon_chk.sv
module hs_mon_chk
  import hs_mon_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 64,
  parameter int WAIT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              ack_rise,
  input logic              req_rise,
  input logic              pending,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic [ERR_N-1:0]  err_pulse,
  input logic [ERR_N-1:0]  err_flags,
  input logic [CNT_W-1:0]  req_count,
  input logic [CNT_W-1:0]  ack_count
);
  // R2
  multi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && pending) |=> err_pulse[ERR_MULTI]);

  // R3
  ack_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && !pending) |=> err_pulse[ERR_NOREQ]);

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WAIT_W'(TIMEOUT));

  // R7
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_pulse & ~err_flags) == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R8
  req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (CNT_W'(req_count - $past(req_count)) <= CNT_W'(1)));

  // R8
  ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (CNT_W'(ack_count - $past(ack_count)) <= CNT_W'(1)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_flags == '0 && req_count == '0 && ack_count == '0));
endmodule

bind hs_handshake_monitor hs_mon_chk #(
  .CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .WAIT_W(WAIT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ack_rise(ack_rise), .req_rise(req_rise),
  .pending(pending), .wait_cnt(wait_cnt), .err_pulse(err_pulse),
  .err_flags(err_flags), .req_count(req_count), .ack_count(ack_count)
);

// File: tb/hs_handshake_monitor_tb.sv
module hs_handshake_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int CW  = 8;
  localparam int TMO = 8;
  localparam int WATCHDOG = 20000;
  localparam int NV = 21;

  // vector: {req, ack, data[8], flags[5], req_count[8], ack_count[8]}
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 5'h00, 8'd0, 8'd0},
    {1'b1, 1'b0, 8'hA5, 5'h00, 8'd1, 8'd0},
    {1'b1, 1'b0, 8'hA5, 5'h00, 8'd1, 8'd0},
    {1'b1, 1'b1, 8'hA5, 5'h00, 8'd1, 8'd0},
    {1'b1, 1'b1, 8'hA5, 5'h00, 8'd1, 8'd0},
    {1'b1, 1'b1, 8'hA5, 5'h00, 8'd1, 8'd1},
    {1'b0, 1'b1, 8'hA5, 5'h00, 8'd1, 8'd1},
    {1'b0, 1'b0, 8'hA5, 5'h00, 8'd1, 8'd1},
    {1'b1, 1'b0, 8'h3C, 5'h00, 8'd2, 8'd1},
    {1'b1, 1'b0, 8'h3D, 5'h10, 8'd2, 8'd1},
    {1'b0, 1'b0, 8'h3D, 5'h14, 8'd2, 8'd1},
    {1'b1, 1'b0, 8'h3D, 5'h15, 8'd3, 8'd1},
    {1'b1, 1'b1, 8'h3D, 5'h15, 8'd3, 8'd1},
    {1'b1, 1'b1, 8'h3D, 5'h15, 8'd3, 8'd1},
    {1'b1, 1'b1, 8'h3D, 5'h15, 8'd3, 8'd2},
    {1'b0, 1'b1, 8'h3D, 5'h15, 8'd3, 8'd2},
    {1'b0, 1'b0, 8'h3D, 5'h15, 8'd3, 8'd2},
    {1'b0, 1'b1, 8'h3D, 5'h15, 8'd3, 8'd2},
    {1'b0, 1'b0, 8'h3D, 5'h15, 8'd3, 8'd2},
    {1'b0, 1'b0, 8'h3D, 5'h17, 8'd3, 8'd3},
    {1'b0, 1'b0, 8'h3D, 5'h17, 8'd3, 8'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          req = 1'b0;
  logic          ack = 1'b0;
  logic [DW-1:0] data = '0;
  logic [4:0]    err_pulse;
  logic [4:0]    err_flags;
  logic [CW-1:0] req_count;
  logic [CW-1:0] ack_count;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_handshake_monitor #(.DATA_W(DW), .CNT_W(CW), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .ack(ack), .data(data),
    .err_pulse(err_pulse), .err_flags(err_flags),
    .req_count(req_count), .ack_count(ack_count)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // advance one rising edge, land a quarter period after it
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    // R10 reset state
    check("R10 flags in reset", err_flags, 0);
    check("R10 pulse in reset", err_pulse, 0);
    check("R10 counts in reset", {req_count, ack_count}, 0);
    rst_n = 1'b1;

    // table walk: R1 latency, R2 R3 R4 R6 flags, R8 edge counts
    for (int i = 0; i < NV; i++) begin
      req  = VEC[i][30];
      ack  = VEC[i][29];
      data = VEC[i][28:21];
      step();
      check($sformatf("R2 R3 R4 R6 flags vec %0d", i), err_flags, VEC[i][20:16]);
      check($sformatf("R8 req count vec %0d", i), req_count, VEC[i][15:8]);
      check($sformatf("R1 R8 ack count vec %0d", i), ack_count, VEC[i][7:0]);
    end

    // R9 clear
    clr = 1'b1;
    step();
    clr = 1'b0;
    check("R9 flags cleared", err_flags, 0);
    check("R9 counts cleared", {req_count, ack_count}, 0);

    // R5 timeout on the TMO-th edge
    req = 1'b1; data = 8'h5A;
    step();
    check("R8 request counted", req_count, 1);
    for (int k = 1; k < TMO; k++) begin
      step();
      check($sformatf("R5 no timeout yet edge %0d", k), err_flags[3], 0);
    end
    step();
    check("R5 timeout pulse", err_pulse[3], 1);
    check("R5 timeout flag", err_flags[3], 1);
    step();
    check("R7 pulse one cycle", err_pulse[3], 0);
    check("R7 flag sticky", err_flags[3], 1);
    ack = 1'b1;
    step(3);
    check("R3 late ack still matched", err_flags, 5'h08);
    check("R8 late ack counted", ack_count, 1);
    req = 1'b0; ack = 1'b0;
    step(3);
    check("R4 drop after ack is legal", err_flags, 5'h08);

    // R6 data change and R4 drop
    clr = 1'b1;
    step();
    clr = 1'b0;
    req = 1'b1; data = 8'h11;
    step();
    data = 8'h22;
    step();
    check("R6 data pulse", err_pulse, 5'h10);
    check("R6 data flag", err_flags, 5'h10);
    step();
    check("R7 data pulse ends", err_pulse, 0);
    req = 1'b0;
    step();
    check("R4 drop pulse", err_pulse, 5'h04);
    check("R4 drop flag", err_flags, 5'h14);

    // R8 saturation
    clr = 1'b1;
    step();
    clr = 1'b0;
    for (int k = 0; k < 260; k++) begin
      req = 1'b1; ack = 1'b1;
      step();
      req = 1'b0; ack = 1'b0;
      step();
    end
    step(3);
    check("R8 req count saturates", req_count, 255);
    check("R8 ack count saturates", ack_count, 255);

    // R10 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 flags after reset", err_flags, 0);
    check("R10 counts after reset", {req_count, ack_count}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule